// File: doc/BRIEF.md
# Leveled interrupt priority controller

This block chooses one interrupt to present to a processor core from fourteen vector slots. Each slot has a priority level from 0 to 3. The level is fixed for most slots and set by configuration for a group of debug-unit sources. A higher level always beats a lower one, and among requests at the same level the smallest vector number wins. The winner is registered and presented with a pending flag. When the core acknowledges it, the block latches the vector number and the fetch address. The fetch address is a programmable base plus twice the vector number, because each slot is two words wide.

Slots 0 and 1 belong to chip reset and watchdog reset. They are kept only as reserved positions and are never chosen. The block supports nesting. It keeps a current level and a small stack of interrupted levels. A new request is presented only when its level is strictly above the current level, except that level-3 requests are presented at any time. A return pulse restores the level that was active before the last acknowledge.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: Request bits 0 and 1 (the reset slots) never raise `irq_pending` and are never presented.
- R2: Vectors 2, 3, 4 and 5 are at level 3 and are presented whatever the current level is.
- R3: Vectors 6 to 10 take their level from `dbg_lvl`. Vector 6+k uses bits [2k+1:2k]. A field value of 0 disables that source; values 1 to 3 are its level.
- R4: Vectors 11, 12 and 13 are at levels 2, 1 and 0.
- R5: Among the eligible requests, the highest level wins. When levels are equal, the lowest vector number wins.
- R6: A request is eligible only if its level is strictly above the current level, or it is at level 3. Out of reset the current level is "idle", which is below level 0.
- R7: `irq_pending` and `pend_vec` are registered. They show the result for the request inputs sampled at the previous clock edge, so a request that drops before acknowledge disappears one cycle later and produces no vector.
- R8: When `ack` is high while `irq_pending` is high, the next cycle shows the following. `vec_num` equals the presented vector. `vec_addr` equals `vec_base + 2*vector`, truncated to AW bits. `irq_pending` is 0. Both `vec_num` and `vec_addr` stay unchanged until the next accepted acknowledge. An `ack` while nothing is pending is ignored.
- R9: An accepted acknowledge makes the winner's level the current level and pushes the previous level onto a stack NEST entries deep. A `rti` pulse pops it back; when the stack is empty, `rti` returns the block to idle. If `rti` and an accepted `ack` occur together, `rti` is ignored. On overflow the oldest entry is lost.
- R10: After reset, `irq_pending`, `pend_vec`, `vec_num` and `vec_addr` are all 0, and the current level is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 14 | Request line per vector slot |
| dbg_lvl | input | 10 | 2-bit level fields for vectors 6 to 10 |
| vec_base | input | AW | Vector table base address |
| ack | input | 1 | Core acknowledges the presented request |
| rti | input | 1 | Return from interrupt; restores previous level |
| irq_pending | output | 1 | An eligible request is being presented |
| pend_vec | output | 4 | Vector number being presented |
| vec_num | output | 4 | Vector number latched at acknowledge |
| vec_addr | output | AW | Fetch address latched at acknowledge |

## Verification
The bench sets up ties at one level and contests between levels. A design with a reversed tie-break, or one that ranks by vector number alone, would present the wrong slot. It raises level-3 sources while the current level is already 3, where a design that applies the strict-above rule to level 3 would lock out the fault vectors. It disables debug sources with a zero field, where a design that treats 0 as level 0 would present them from idle. It also checks the sequence of return pulses: a stack that pops in the wrong order or loses depth would present requests that ought to stay masked, or mask requests that ought to be presented.

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int AW   = 16,
  parameter int NEST = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [13:0]   irq_req,
  input  logic [9:0]    dbg_lvl,
  input  logic [AW-1:0] vec_base,
  input  logic          ack,
  input  logic          rti,
  output logic          irq_pending,
  output logic [3:0]    pend_vec,
  output logic [3:0]    vec_num,
  output logic [AW-1:0] vec_addr
);
  localparam int NV = 14;

  logic [1:0]    lvl [NV];
  logic [NV-1:0] en;
  logic [NV-1:0] elig;
  logic [2:0]    stk [NEST];
  logic          found;
  logic [3:0]    win;
  logic [1:0]    win_lvl;
  logic          pend_q;
  logic [3:0]    win_q;
  logic [1:0]    wlvl_q;
  logic          take;

  assign lvl[0]  = 2'd0;  assign en[0]  = 1'b0;
  assign lvl[1]  = 2'd0;  assign en[1]  = 1'b0;
  assign lvl[2]  = 2'd3;  assign en[2]  = 1'b1;
  assign lvl[3]  = 2'd3;  assign en[3]  = 1'b1;
  assign lvl[4]  = 2'd3;  assign en[4]  = 1'b1;
  assign lvl[5]  = 2'd3;  assign en[5]  = 1'b1;
  assign lvl[11] = 2'd2;  assign en[11] = 1'b1;
  assign lvl[12] = 2'd1;  assign en[12] = 1'b1;
  assign lvl[13] = 2'd0;  assign en[13] = 1'b1;

  for (genvar k = 0; k < 5; k++) begin : g_dbg
    assign lvl[6+k] = dbg_lvl[2*k +: 2];
    assign en[6+k]  = |dbg_lvl[2*k +: 2];
  end

  for (genvar i = 0; i < NV; i++) begin : g_elig
    assign elig[i] = irq_req[i] && en[i] &&
                     (({1'b0, lvl[i]} + 3'd1 > stk[0]) || lvl[i] == 2'd3);
  end

  always_comb begin
    found   = 1'b0;
    win     = 4'd0;
    win_lvl = 2'd0;
    for (int l = 3; l >= 0; l--) begin
      for (int i = 0; i < NV; i++) begin
        if (!found && elig[i] && int'(lvl[i]) == l) begin
          found   = 1'b1;
          win     = 4'(i);
          win_lvl = 2'(l);
        end
      end
    end
  end

  assign take = ack && pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      win_q    <= '0;
      wlvl_q   <= '0;
      vec_num  <= '0;
      vec_addr <= '0;
    end else if (take) begin
      pend_q   <= 1'b0;
      vec_num  <= win_q;
      vec_addr <= vec_base + AW'({win_q, 1'b0});
    end else begin
      pend_q   <= found;
      win_q    <= win;
      wlvl_q   <= win_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NEST; k++) stk[k] <= 3'd0;
    end else if (take) begin
      stk[0] <= {1'b0, wlvl_q} + 3'd1;
      for (int k = 1; k < NEST; k++) stk[k] <= stk[k-1];
    end else if (rti) begin
      for (int k = 0; k < NEST - 1; k++) stk[k] <= stk[k+1];
      stk[NEST-1] <= 3'd0;
    end
  end

  assign irq_pending = pend_q;
  assign pend_vec    = win_q;
endmodule

// File: rtl/lvl_irq_chk.sv
module lvl_irq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [13:0]   irq_req,
  input logic [AW-1:0] vec_base,
  input logic          ack,
  input logic          irq_pending,
  input logic [3:0]    pend_vec,
  input logic [3:0]    vec_num,
  input logic [AW-1:0] vec_addr
);
  p_no_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> pend_vec >= 4'd2);

  p_fault_always_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req[2] && !(ack && irq_pending)) |=> irq_pending);

  p_fault_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req[2] && !(ack && irq_pending)) |=> pend_vec == 4'd2);

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_pending) |=> !irq_pending);

  p_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_pending) |=>
      (vec_num == $past(pend_vec)) &&
      (vec_addr == $past(vec_base) + AW'({$past(pend_vec), 1'b0})));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && irq_pending) |=> $stable(vec_num) && $stable(vec_addr));

  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req == 14'd0) |=> !irq_pending);
endmodule

bind lvl_irq_ctrl lvl_irq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .vec_base(vec_base),
  .ack(ack), .irq_pending(irq_pending), .pend_vec(pend_vec),
  .vec_num(vec_num), .vec_addr(vec_addr)
);

// File: tb/test_lvl_irq_ctrl.sv
module test_lvl_irq_ctrl;
  localparam int AW = 16;
  localparam int NEST = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [13:0]   irq_req = '0;
  logic [9:0]    dbg_lvl = '0;
  logic [AW-1:0] vec_base = '0;
  logic          ack = 1'b0;
  logic          rti = 1'b0;
  logic          irq_pending;
  logic [3:0]    pend_vec;
  logic [3:0]    vec_num;
  logic [AW-1:0] vec_addr;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lvl_irq_ctrl #(.AW(AW), .NEST(NEST)) i_lvl_irq_ctrl (.*);

  // behavioural reference
  bit       m_pend;
  int       m_pvec, m_plvl, m_vnum, m_vaddr;
  int       m_stack[$];

  function automatic int level_of(int v, logic [9:0] cfg);
    if (v < 2) return -1;
    if (v < 6) return 3;
    if (v < 11) return (cfg[2*(v-6) +: 2] == 2'd0) ? -1 : int'(cfg[2*(v-6) +: 2]);
    return 13 - v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_pvec = 0; m_plvl = 0; m_vnum = 0; m_vaddr = 0;
      m_stack.delete();
    end else begin
      int cur, best, bestl;
      cur = (m_stack.size() == 0) ? -1 : m_stack[0];
      best = -1; bestl = -1;
      for (int v = 0; v < 14; v++) begin
        int l;
        l = level_of(v, dbg_lvl);
        if (irq_req[v] && l >= 0 && (l > cur || l == 3) && l > bestl) begin
          best = v; bestl = l;
        end
      end
      if (ack && m_pend) begin
        m_vnum  = m_pvec;
        m_vaddr = (int'(vec_base) + 2 * m_pvec) % (1 << AW);
        m_stack.push_front(m_plvl);
        if (m_stack.size() > NEST) void'(m_stack.pop_back());
        m_pend = 0;
      end else begin
        if (rti && m_stack.size() > 0) void'(m_stack.pop_front());
        m_pend = (best >= 0);
        m_pvec = (best >= 0) ? best : 0;
        m_plvl = (best >= 0) ? bestl : 0;
      end
    end
  end

  task automatic check(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check("R7 model pending", int'(irq_pending), int'(m_pend));
      if (m_pend) check("R5 model vector", int'(pend_vec), m_pvec);
      check("R8 model vec_num", int'(vec_num), m_vnum);
      check("R8 model vec_addr", int'(vec_addr), m_vaddr);
    end
    if (cycles > 20000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic pulse_rti();
    rti = 1'b1; tick(); rti = 1'b0;
  endtask

  initial begin
    vec_base = 16'h1000;
    tick(2);
    check("R10 reset pending", int'(irq_pending), 0);
    check("R10 reset vec_num", int'(vec_num), 0);
    check("R10 reset vec_addr", int'(vec_addr), 0);
    rst_n = 1'b1;
    tick();

    // R1: reserved slots
    irq_req = 14'b11; tick(2);
    check("R1 reserved not presented", int'(irq_pending), 0);
    irq_req = '0; tick();

    // R4/R6: level-0 source from idle
    irq_req[13] = 1'b1; tick();
    check("R6 idle accepts level 0", int'(irq_pending), 1);
    check("R4 vector 13 presented", int'(pend_vec), 13);
    pulse_ack();
    check("R8 vec_num after ack", int'(vec_num), 13);
    check("R8 vec_addr base+0x1A", int'(vec_addr), 16'h101A);
    check("R8 pending cleared", int'(irq_pending), 0);
    tick(2);
    check("R6 same level masked", int'(irq_pending), 0);

    // R4/R6: level 1 above current level 0
    irq_req[12] = 1'b1; tick(2);
    check("R6 higher level presented", int'(pend_vec), 12);
    pulse_ack();
    check("R8 addr for vector 12", int'(vec_addr), 16'h1018);
    tick(2);
    check("R6 masked at level 1", int'(irq_pending), 0);
    check("R8 vec_num held", int'(vec_num), 12);
    pulse_rti();
    tick();
    check("R9 rti restores level 0", int'(irq_pending), 1);
    check("R9 vector 12 back", int'(pend_vec), 12);
    pulse_rti();
    tick();
    check("R5 level 1 beats level 0", int'(pend_vec), 12);

    // ack with nothing pending is ignored
    irq_req = '0; tick(2);
    pulse_ack(); tick();
    check("R8 idle ack ignored", int'(vec_num), 12);

    // R2/R5: level 3 under level 2
    irq_req[11] = 1'b1; tick(2);
    check("R4 vector 11 presented", int'(pend_vec), 11);
    pulse_ack(); tick();
    irq_req[5] = 1'b1; irq_req[4] = 1'b1; tick(2);
    check("R5 lowest vector at level 3", int'(pend_vec), 4);
    pulse_ack(); tick();
    irq_req[4] = 1'b0; irq_req[3] = 1'b1; tick(2);
    check("R2 level 3 while at level 3", int'(pend_vec), 3);
    pulse_ack();
    check("R2 addr vector 3", int'(vec_addr), 16'h1006);
    irq_req = '0;
    repeat (4) pulse_rti();
    tick();

    // R3: configurable debug levels
    dbg_lvl = 10'b00_00_00_11_00;
    irq_req[6] = 1'b1; irq_req[7] = 1'b1; tick(2);
    check("R3 field 3 wins, field 0 off", int'(pend_vec), 7);
    dbg_lvl = '0; tick(2);
    check("R3 zero fields disable", int'(irq_pending), 0);
    dbg_lvl = 10'b10_00_00_00_01;
    irq_req[10] = 1'b1; irq_req[13] = 1'b1; tick(2);
    check("R3 vector 10 at level 2", int'(pend_vec), 10);

    // R7: drop before ack
    irq_req = '0; dbg_lvl = '0;
    tick(2);
    irq_req[12] = 1'b1; tick();
    check("R7 presented", int'(irq_pending), 1);
    irq_req[12] = 1'b0; tick();
    check("R7 dropped", int'(irq_pending), 0);

    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      irq_req  = 14'($urandom) & 14'($urandom);
      if (n % 64 == 0) dbg_lvl = 10'($urandom);
      if (n % 200 == 0) vec_base = 16'($urandom);
      ack = ($urandom % 3) == 0;
      rti = ($urandom % 4) == 0;
      tick();
    end
    ack = 0; rti = 0;
    tick(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule